// File: doc/BRIEF.md
# HDLC Frame Transmitter

This block turns characters and commands from a processor into a bit-oriented serial frame stream. It sends one bit on every rising edge of its transmit clock. A start-of-message command opens a frame with a flag. Each data character that follows is shifted out least significant bit first, and zero insertion keeps the data free of flag patterns. An end-of-message command appends an inverted 16-bit CRC and a closing flag. Commands can also abort the frame in progress or send a go-ahead pattern between frames.

The processor side is a single-entry buffer. `buf_empty` asks for the next entry, and each write carries a kind code together with a character. If the buffer is still empty when the transmitter needs the next character, the block raises `underrun` and ends the frame with an abort. Between frames the line carries flags or continuous mark, as `fill_flags` selects. When `tx_en` goes low, the current frame runs to its closing flag. The block then drops `tx_active` and holds the line at mark.

Top module: `hdlc_frame_tx`

## Requirements
- R1: While reset is held, `txd` is 1, `buf_empty` is 1, and both `tx_active` and `underrun` are 0.
- R2: Between frames, the line sends continuous 1s when `tx_en` is low or `fill_flags` is 0. When both are high, the line sends back-to-back flags 01111110 (first bit on the line 0).
- R3: A start-of-message entry (`wr_kind`=1) is taken at the next unit boundary between frames, provided `tx_en` is high. That boundary loads the opening flag, and in the same cycle `tx_active` rises and `buf_empty` rises.
- R4: Data entries (`wr_kind`=0) go out least significant bit first. Inside a frame, a 0 follows every run of five 1s in the data and in the check field. Flags, aborts and go-ahead patterns carry no inserted zeros.
- R5: An end-of-message entry (`wr_kind`=2) sends the check field and then a closing flag. The check field is the one's complement of a CRC over the frame's data bits in line order, using x^16+x^12+x^5+1 with the register preset to all ones, and it goes out most significant bit first.
- R6: A write while `buf_empty` is 1 is accepted, and `buf_empty` reads 0 in the following cycle. A write while `buf_empty` is 0 is ignored and does not change the transmitted frame.
- R7: If the buffer is empty when a frame needs its next entry, `underrun` rises and the frame ends with a run of at least eight 1s. After the opening flag, that happens exactly eight bit times after `buf_empty` rises. A frame whose buffer is always serviced in time never raises `underrun`.
- R8: An accepted start-of-message write clears `underrun`, which reads 0 in the following cycle.
- R9: An abort entry (`wr_kind`=3) inside a frame ends it with eight 1s, and no complete frame is delivered. Start-of-message or go-ahead entries that arrive inside a frame also abort it.
- R10: A go-ahead entry (`wr_kind`=4) taken between frames sends a 0 followed by seven 1s, with no inserted zero.
- R11: When `tx_en` is low at the end of a closing flag, `tx_active` falls and `txd` stays at 1 afterwards. Dropping `tx_en` in the middle of a frame does not cut the frame short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock; one line bit per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable |
| fill_flags | input | 1 | Between-frame fill: 1 flags, 0 mark |
| wr_en | input | 1 | Buffer write strobe |
| wr_kind | input | 3 | Entry kind: 0 data, 1 start, 2 end, 3 abort, 4 go-ahead |
| wr_char | input | 8 | Data character for kind 0 |
| txd | output | 1 | Serial line output, mark is 1 |
| buf_empty | output | 1 | Buffer can take a new entry |
| tx_active | output | 1 | Transmitter is inside a message sequence |
| underrun | output | 1 | Buffer was not serviced in time |

## Verification
Most internal faults show up on the serial line within one character time. A wrong shift count or a wrong ones counter either breaks the flag framing or leaves a run of six 1s inside a frame, so the frame is no longer decoded. A wrong CRC register shows up only in the 16 check bits at the end of the frame, so a decoder has to compare those bits with an independently computed CRC. Faults in the buffer flag and the underrun flag are visible at the ports within one to eight cycles, and their timing is checked against exact cycle counts.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
    typedef enum logic [2:0] {
        K_DATA  = 3'd0,
        K_SOM   = 3'd1,
        K_EOM   = 3'd2,
        K_ABORT = 3'd3,
        K_GA    = 3'd4
    } kind_e;

    typedef enum logic [2:0] {
        U_FILL, U_OPEN, U_DATA, U_FCS, U_CLOSE, U_ABORT, U_GA
    } unit_e;

    localparam int PAT_W = 8;
    // patterns shift out LSB first
    localparam logic [PAT_W-1:0] PAT_FLAG = 8'h7E;
    localparam logic [PAT_W-1:0] PAT_ONES = 8'hFF;
    localparam logic [PAT_W-1:0] PAT_GA   = 8'hFE;
endpackage

// File: rtl/hdlc_fcs_step.sv
module hdlc_fcs_step #(
    parameter int            W    = 16,
    parameter logic [W-1:0]  POLY = 16'h1021
) (
    input  logic [W-1:0] crc_i,
    input  logic         bit_i,
    input  logic         en_i,
    output logic [W-1:0] crc_o
);
    logic fb;

    always_comb begin
        fb    = crc_i[W-1] ^ bit_i;
        crc_o = crc_i;
        if (en_i) begin
            crc_o = {crc_i[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end
endmodule

// File: rtl/hdlc_bit_stuffer.sv
module hdlc_bit_stuffer #(
    parameter int RUN    = 5,
    parameter int ONES_W = 3
) (
    input  logic [ONES_W-1:0] ones_i,
    input  logic              stuff_en_i,
    input  logic              bit_i,
    output logic              line_o,
    output logic              take_o,
    output logic [ONES_W-1:0] ones_o
);
    localparam logic [ONES_W-1:0] RUN_C = ONES_W'(RUN);
    logic stuff;

    always_comb begin
        stuff  = stuff_en_i && (ones_i == RUN_C);
        line_o = stuff ? 1'b0 : bit_i;
        take_o = !stuff;
        if (!stuff_en_i || stuff || !bit_i) begin
            ones_o = '0;
        end else begin
            ones_o = ones_i + 1'b1;
        end
    end
endmodule

// File: rtl/hdlc_frame_tx.sv
module hdlc_frame_tx
    import hdlc_tx_pkg::*;
#(
    parameter int                CHAR_W    = 8,
    parameter int                FCS_W     = 16,
    parameter logic [FCS_W-1:0]  FCS_POLY  = 16'h1021,
    parameter int                STUFF_RUN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              fill_flags,
    input  logic              wr_en,
    input  logic [2:0]        wr_kind,
    input  logic [CHAR_W-1:0] wr_char,
    output logic              txd,
    output logic              buf_empty,
    output logic              tx_active,
    output logic              underrun
);
    localparam int SH_W   = (FCS_W > CHAR_W) ? FCS_W : CHAR_W;
    localparam int CNT_W  = $clog2(SH_W + 1);
    localparam int ONES_W = $clog2(STUFF_RUN + 1);
    localparam logic [ONES_W-1:0] RUN_C = ONES_W'(STUFF_RUN);

    typedef struct packed {
        logic [SH_W-1:0]   sh;
        logic [CNT_W-1:0]  left;
        logic [ONES_W-1:0] ones;
        logic              stuff_en;
        logic              crc_en;
        unit_e             unit;
        logic [FCS_W-1:0]  crc;
        logic              hold_v;
        kind_e             hold_k;
        logic [CHAR_W-1:0] hold_c;
        logic              active;
        logic              urun;
        logic              txd;
    } st_t;

    st_t q, d;

    logic              line_bit, take_bit, unit_end, wr_ok;
    logic [ONES_W-1:0] ones_nx;
    logic [FCS_W-1:0]  crc_nx;
    logic [FCS_W-1:0]  fcs_line;

    function automatic st_t load_pat(st_t s, logic [PAT_W-1:0] p, unit_e u);
        st_t r = s;
        r.sh       = SH_W'(p);
        r.left     = CNT_W'(PAT_W);
        r.ones     = '0;
        r.stuff_en = 1'b0;
        r.crc_en   = 1'b0;
        r.unit     = u;
        return r;
    endfunction

    hdlc_bit_stuffer #(.RUN(STUFF_RUN), .ONES_W(ONES_W)) u_stuff (
        .ones_i    (q.ones),
        .stuff_en_i(q.stuff_en),
        .bit_i     (q.sh[0]),
        .line_o    (line_bit),
        .take_o    (take_bit),
        .ones_o    (ones_nx)
    );

    hdlc_fcs_step #(.W(FCS_W), .POLY(FCS_POLY)) u_fcs (
        .crc_i(q.crc),
        .bit_i(q.sh[0]),
        .en_i (q.crc_en),
        .crc_o(crc_nx)
    );

    always_comb begin
        d        = q;
        d.txd    = line_bit;
        d.ones   = ones_nx;
        fcs_line = '0;
        if (take_bit && q.left != '0) begin
            d.sh   = q.sh >> 1;
            d.left = q.left - 1'b1;
            d.crc  = crc_nx;
        end
        // line order of check field is MSB first; shifter sends LSB first
        for (int i = 0; i < FCS_W; i++) begin
            fcs_line[i] = ~d.crc[FCS_W-1-i];
        end
        unit_end = (d.left == '0) && !(q.stuff_en && d.ones == RUN_C);
        wr_ok    = wr_en && !q.hold_v;
        if (wr_ok) begin
            d.hold_v = 1'b1;
            d.hold_k = kind_e'(wr_kind);
            d.hold_c = wr_char;
        end
        if (unit_end) begin
            if (q.unit == U_FCS) begin
                d = load_pat(d, PAT_FLAG, U_CLOSE);
            end else if (q.unit == U_OPEN || q.unit == U_DATA) begin
                if (!q.hold_v) begin
                    d.urun = 1'b1;
                    d = load_pat(d, PAT_ONES, U_ABORT);
                end else begin
                    d.hold_v = 1'b0;
                    if (q.hold_k == K_DATA) begin
                        d.sh       = SH_W'(q.hold_c);
                        d.left     = CNT_W'(CHAR_W);
                        d.stuff_en = 1'b1;
                        d.crc_en   = 1'b1;
                        d.unit     = U_DATA;
                    end else if (q.hold_k == K_EOM) begin
                        d.sh       = SH_W'(fcs_line);
                        d.left     = CNT_W'(FCS_W);
                        d.stuff_en = 1'b1;
                        d.crc_en   = 1'b0;
                        d.unit     = U_FCS;
                    end else begin
                        d = load_pat(d, PAT_ONES, U_ABORT);
                    end
                end
            end else begin
                d.active = q.active && tx_en;
                d = load_pat(d, (tx_en && fill_flags) ? PAT_FLAG : PAT_ONES, U_FILL);
                if (tx_en && q.hold_v) begin
                    d.hold_v = 1'b0;
                    if (q.hold_k == K_SOM) begin
                        d = load_pat(d, PAT_FLAG, U_OPEN);
                        d.active = 1'b1;
                        d.crc    = '1;
                    end else if (q.hold_k == K_GA) begin
                        d = load_pat(d, PAT_GA, U_GA);
                    end
                end
            end
        end
        if (wr_ok && kind_e'(wr_kind) == K_SOM) begin
            d.urun = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.sh       <= SH_W'(PAT_ONES);
            q.left     <= CNT_W'(PAT_W);
            q.unit     <= U_FILL;
            q.crc      <= '1;
            q.hold_k   <= K_DATA;
            q.txd      <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign txd       = q.txd;
    assign buf_empty = !q.hold_v;
    assign tx_active = q.active;
    assign underrun  = q.urun;

    AST_STUFF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.stuff_en |-> q.ones <= RUN_C); // R4
    AST_BE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && buf_empty) |=> !buf_empty); // R6
    AST_UR_SOM_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && buf_empty && wr_kind == 3'd1) |=> !underrun); // R8
    AST_ACTIVE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |-> q.unit == U_OPEN); // R3
    AST_UR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> q.unit == U_ABORT); // R7
endmodule

// File: tb/sim_hdlc_frame_tx.sv
`timescale 1ns/1ps
module sim_hdlc_frame_tx;
    import hdlc_tx_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       fill_flags = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_kind = 3'd0;
    logic [7:0] wr_char = 8'd0;
    logic       txd, buf_empty, tx_active, underrun;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    int ones_run = 0;
    bit in_fr = 1'b0;
    logic rxbits[$];
    int flag_cnt = 0, abort_cnt = 0, ga_cnt = 0, stuff_cnt = 0, frame_cnt = 0;
    int exp_len[$];
    logic [7:0] exp_bytes[$];
    logic [7:0] tx_bytes[$];

    always #2.5 clk = ~clk;

    hdlc_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .fill_flags(fill_flags),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_char(wr_char),
        .txd(txd), .buf_empty(buf_empty), .tx_active(tx_active), .underrun(underrun)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_bytes(input int first, input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 8; k++) begin
                logic fb = c[15] ^ exp_bytes[first + i][k];
                c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
            end
        end
        return c;
    endfunction

    task automatic decode_frame(input int n);
        int elen, nb, bad;
        logic [15:0] rx_fcs, want;
        frame_cnt++;
        if (exp_len.size() == 0) begin
            chk(1'b0, "R5", "unexpected frame bits", n, 0);
            return;
        end
        elen = exp_len.pop_front();
        nb = (n - 16) / 8;
        chk((n % 8 == 0) && nb == elen, "R4", "frame data length", nb, elen);
        bad = 0;
        for (int i = 0; i < elen; i++) begin
            logic [7:0] got = 8'h00;
            for (int k = 0; k < 8; k++) begin
                if (i * 8 + k < n) got[k] = rxbits[i * 8 + k];
            end
            if (got !== exp_bytes[i]) bad++;
        end
        chk(bad == 0, "R4", "data bytes mismatched", bad, 0);
        rx_fcs = 16'h0;
        for (int k = 0; k < 16; k++) begin
            if (n - 16 + k >= 0) rx_fcs[15 - k] = rxbits[n - 16 + k];
        end
        want = ~crc_bytes(0, elen);
        chk(rx_fcs == want, "R5", "check field", rx_fcs, want);
        for (int i = 0; i < elen; i++) void'(exp_bytes.pop_front());
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (txd) begin
                ones_run++;
                if (ones_run == 8) abort_cnt++;
                if (ones_run == 7) begin
                    in_fr = 1'b0;
                    rxbits.delete();
                end else if (in_fr) begin
                    rxbits.push_back(1'b1);
                end
            end else begin
                if (ones_run == 7) ga_cnt++;
                if (ones_run == 6) begin
                    flag_cnt++;
                    if (in_fr && rxbits.size() > 7) decode_frame(rxbits.size() - 7);
                    in_fr = 1'b1;
                    rxbits.delete();
                end else if (ones_run == 5 && in_fr) begin
                    stuff_cnt++;
                end else if (in_fr) begin
                    rxbits.push_back(1'b0);
                end
                ones_run = 0;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "ALL", "watchdog cycles", cyc, 150000);
            summary();
        end
    end

    task automatic wr(input logic [2:0] k, input logic [7:0] c);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = k; wr_char = c;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_be();
        int g = 0;
        while (!buf_empty && g < 1000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic wait_frames(input int target);
        int g = 0;
        while (frame_cnt < target && g < 2000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic send_frame();
        exp_len.push_back(tx_bytes.size());
        foreach (tx_bytes[i]) exp_bytes.push_back(tx_bytes[i]);
        wait_be();
        wr(3'd1, 8'h00);
        foreach (tx_bytes[i]) begin
            wait_be();
            wr(3'd0, tx_bytes[i]);
        end
        wait_be();
        wr(3'd2, 8'h00);
    endtask

    initial begin
        int f0, a0, g0, s0, bad, n, t;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1", "txd in reset", txd, 1);
        chk(buf_empty == 1'b1, "R1", "buf_empty in reset", buf_empty, 1);
        chk(tx_active == 1'b0, "R1", "tx_active in reset", tx_active, 0);
        chk(underrun == 1'b0, "R1", "underrun in reset", underrun, 0);
        rst_n = 1'b1;
        // R2 mark while disabled
        bad = 0;
        repeat (24) begin @(negedge clk); if (txd !== 1'b1) bad++; end
        chk(bad == 0, "R2", "zeros while disabled", bad, 0);
        // R2 mark fill while enabled with fill_flags=0
        tx_en = 1'b1;
        repeat (10) @(negedge clk);
        bad = 0;
        repeat (24) begin @(negedge clk); if (txd !== 1'b1) bad++; end
        chk(bad == 0, "R2", "zeros in mark fill", bad, 0);
        // R2 flag fill
        fill_flags = 1'b1;
        f0 = flag_cnt;
        repeat (48) @(negedge clk);
        chk(flag_cnt - f0 >= 4, "R2", "flags in flag fill", flag_cnt - f0, 4);
        chk(frame_cnt == 0, "R2", "frames during fill", frame_cnt, 0);
        // R3, R4, R5 directed frame with stuffing patterns
        chk(tx_active == 1'b0, "R3", "active before start", tx_active, 0);
        tx_bytes = '{8'hFF, 8'h7E, 8'h3E, 8'h00, 8'hF8};
        exp_len.push_back(tx_bytes.size());
        foreach (tx_bytes[i]) exp_bytes.push_back(tx_bytes[i]);
        s0 = stuff_cnt;
        wr(3'd1, 8'h00);
        chk(buf_empty == 1'b0, "R6", "buf_empty after write", buf_empty, 0);
        wait_be();
        chk(tx_active == 1'b1, "R3", "active with opening flag", tx_active, 1);
        foreach (tx_bytes[i]) begin wait_be(); wr(3'd0, tx_bytes[i]); end
        wait_be();
        wr(3'd2, 8'h00);
        wait_frames(1);
        chk(frame_cnt == 1, "R5", "directed frame count", frame_cnt, 1);
        chk(stuff_cnt - s0 >= 2, "R4", "inserted zeros", stuff_cnt - s0, 2);
        // R6 write while full ignored
        exp_len.push_back(1);
        exp_bytes.push_back(8'hA5);
        wait_be();
        wr(3'd1, 8'h00);
        wait_be();
        wr(3'd0, 8'hA5);
        wr(3'd0, 8'h5A);
        wait_be();
        wr(3'd2, 8'h00);
        wait_frames(2);
        chk(frame_cnt == 2, "R6", "frame after ignored write", frame_cnt, 2);
        // random frames
        for (int fr = 0; fr < 20; fr++) begin
            tx_bytes.delete();
            n = 1 + int'($urandom % 8);
            for (int i = 0; i < n; i++) begin
                if ($urandom % 4 == 0) tx_bytes.push_back(8'hFF);
                else tx_bytes.push_back(8'($urandom));
            end
            send_frame();
        end
        wait_frames(22);
        chk(frame_cnt == 22, "R5", "random frame count", frame_cnt, 22);
        chk(underrun == 1'b0, "R7", "underrun with serviced buffer", underrun, 0);
        // R7 underrun timing and abort
        repeat (30) @(negedge clk);
        a0 = abort_cnt;
        wr(3'd1, 8'h00);
        wait_be();
        t = 0;
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            if (underrun && t == 0) t = k;
        end
        chk(t == 8, "R7", "bit times to underrun", t, 8);
        chk(abort_cnt - a0 == 1, "R7", "abort after underrun", abort_cnt - a0, 1);
        // R8 start clears underrun
        wr(3'd1, 8'h00);
        chk(underrun == 1'b0, "R8", "underrun after start", underrun, 0);
        exp_len.push_back(1);
        exp_bytes.push_back(8'h11);
        wait_be();
        wr(3'd0, 8'h11);
        wait_be();
        wr(3'd2, 8'h00);
        wait_frames(23);
        chk(frame_cnt == 23, "R8", "frame after underrun", frame_cnt, 23);
        // R9 abort command
        repeat (20) @(negedge clk);
        a0 = abort_cnt;
        f0 = frame_cnt;
        wr(3'd1, 8'h00);
        wait_be();
        wr(3'd0, 8'h12);
        wait_be();
        wr(3'd3, 8'h00);
        repeat (50) @(negedge clk);
        chk(abort_cnt - a0 == 1, "R9", "aborts seen", abort_cnt - a0, 1);
        chk(frame_cnt == f0, "R9", "frames after abort", frame_cnt, f0);
        // R10 go-ahead
        g0 = ga_cnt;
        a0 = abort_cnt;
        wr(3'd4, 8'h00);
        repeat (40) @(negedge clk);
        chk(ga_cnt - g0 == 1, "R10", "go-ahead patterns", ga_cnt - g0, 1);
        chk(abort_cnt == a0, "R10", "aborts during go-ahead", abort_cnt, a0);
        // R11 shutdown
        exp_len.push_back(1);
        exp_bytes.push_back(8'h81);
        wr(3'd1, 8'h00);
        wait_be();
        wr(3'd0, 8'h81);
        tx_en = 1'b0;
        chk(tx_active == 1'b1, "R11", "active mid frame", tx_active, 1);
        wait_be();
        wr(3'd2, 8'h00);
        t = 0;
        while (tx_active && t < 300) begin @(negedge clk); t++; end
        chk(tx_active == 1'b0, "R11", "active after closing flag", tx_active, 0);
        bad = 0;
        repeat (16) begin @(negedge clk); if (txd !== 1'b1) bad++; end
        chk(bad == 0, "R11", "zeros after shutdown", bad, 0);
        chk(frame_cnt == 24, "R11", "frame completed at shutdown", frame_cnt, 24);
        chk(exp_len.size() == 0, "R5", "frames still expected", exp_len.size(), 0);
        summary();
    end
endmodule